// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block is the slave side of an interrupt acknowledge handshake on an asynchronous bus with active-low strobes. The host signals an acknowledge by pulling both the acknowledge input and the lower data strobe low. The block answers by driving an 8-bit vector number onto the low data byte and pulling its transfer-acknowledge output low. It keeps that answer on the bus until the host lets go of either strobe.

After the host releases a strobe, the block hands the bus back in three single-clock steps. First the data byte floats. Then the acknowledge line is driven high, so it is actively negated. Then the acknowledge line floats as well. Tri-state pads sit outside the block: each three-state output comes with its own enable.

The strobes are brought into the block clock through a two-stage synchronizer. The vector comes from a register that the host can load, and a new value takes effect at the next acknowledge cycle. A new cycle starts only after both strobes have been seen released.

Top module: `iack_vector_responder`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `data_oe` and `dtack_oe` are 0. The vector register holds 8'h0F, so a cycle run without loading the register returns 8'h0F.
- R2: With both `iack_n` and `lds_n` low and the block armed, the block enters the drive state no later than three clock edges after the inputs settle. In that state `data_out` carries the vector, `data_oe`=1, `dtack_oe`=1 and `dtack_out`=0. Whenever `data_oe` is 1, the acknowledge is driven asserted.
- R3: If only one of `iack_n` and `lds_n` is low, no cycle starts: `data_oe` and `dtack_oe` stay 0.
- R4: During the drive state, `data_out` holds the value captured at the start of the cycle. A write to the vector register during that state does not change it.
- R5: When either strobe goes high, the release runs in this order. First `data_oe` falls while the acknowledge is still driven low. Next `dtack_out`=1 with `dtack_oe`=1. Only after that does `dtack_oe` fall.
- R6: Each release step lasts exactly one clock. The driven-negated acknowledge (`dtack_oe`=1 and `dtack_out`=1) is present for a single cycle. `data_oe` falls three edges after the strobe goes high.
- R7: `addr`, `uds_n` and `rw_n` have no effect on any output.
- R8: A new cycle needs both strobes to be seen high after the previous cycle. Releasing only one strobe and then asserting it again does not start a cycle.
- R9: A write through `vec_wr_en`/`vec_wr_data` sets the vector returned by the next acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| iack_n | input | 1 | Interrupt acknowledge strobe, active low, asynchronous |
| lds_n | input | 1 | Lower data strobe, active low, asynchronous |
| uds_n | input | 1 | Upper strobe / byte address, ignored |
| rw_n | input | 1 | Read/write, ignored |
| addr | input | ADDR_W | Address bus, ignored |
| vec_wr_en | input | 1 | Load strobe for the vector register |
| vec_wr_data | input | VEC_W | New vector value |
| data_out | output | VEC_W | Vector byte toward the data pads |
| data_oe | output | 1 | Enable for the data pads |
| dtack_out | output | 1 | Transfer-acknowledge level, active low |
| dtack_oe | output | 1 | Enable for the acknowledge pad |

## Verification
The assertions check the output relationships on every cycle. They confirm that the data byte is never enabled without an asserted acknowledge and that the data floats before the acknowledge is negated. They also confirm that the negated acknowledge is driven for exactly one clock before it floats, and that the byte stays steady while it is enabled. Only the bench scenarios can show the input-to-output parts of the behaviour. These are the start and release latency through the synchronizer, the refusal to respond to a single strobe, re-arming, insensitivity to address and upper strobe, and which vector value a cycle returns after register writes.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_DRIVE     = 3'd1,
    ST_REL_DATA  = 3'd2,
    ST_NEG_ACK   = 3'd3,
    ST_FLOAT_ACK = 3'd4
  } resp_state_e;
endpackage

// File: rtl/iack_sync.sv
module iack_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/iack_vec_reg.sv
module iack_vec_reg #(
  parameter int             VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_data,
  output logic [VEC_W-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst)        vec <= RST_VEC;
    else if (wr_en) vec <= wr_data;
  end
endmodule

// File: rtl/iack_seq_fsm.sv
module iack_seq_fsm
  import iack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_act,
  input  logic             lds_act,
  input  logic [VEC_W-1:0] vec_in,
  output logic [VEC_W-1:0] data_out,
  output logic             data_oe,
  output logic             dtack_out,
  output logic             dtack_oe
);
  resp_state_e state_q, state_d;
  logic        armed_q;
  logic        both_act, both_idle, start;

  assign both_act  = ack_act & lds_act;
  assign both_idle = ~ack_act & ~lds_act;
  assign start     = (state_q == ST_IDLE) & both_act & armed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (start)     state_d = ST_DRIVE;
      ST_DRIVE:     if (!both_act) state_d = ST_REL_DATA;
      ST_REL_DATA:                 state_d = ST_NEG_ACK;
      ST_NEG_ACK:                  state_d = ST_FLOAT_ACK;
      ST_FLOAT_ACK:                state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start)          armed_q <= 1'b0;
      else if (both_idle) armed_q <= 1'b1;
    end
  end

  // Outputs registered from the next-state decode so pads see clean edges.
  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      data_oe   <= 1'b0;
      dtack_out <= 1'b1;
      dtack_oe  <= 1'b0;
    end else begin
      if (start) data_out <= vec_in;
      data_oe   <= (state_d == ST_DRIVE);
      dtack_out <= !((state_d == ST_DRIVE) || (state_d == ST_REL_DATA));
      dtack_oe  <= (state_d == ST_DRIVE) || (state_d == ST_REL_DATA) ||
                   (state_d == ST_NEG_ACK);
    end
  end
endmodule

// File: rtl/iack_vector_responder.sv
module iack_vector_responder #(
  parameter int               VEC_W   = 8,
  parameter int               ADDR_W  = 23,
  parameter int               SYNC_N  = 2,
  parameter logic [VEC_W-1:0] RST_VEC = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iack_n,
  input  logic              lds_n,
  input  logic              uds_n,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vec_wr_en,
  input  logic [VEC_W-1:0]  vec_wr_data,
  output logic [VEC_W-1:0]  data_out,
  output logic              data_oe,
  output logic              dtack_out,
  output logic              dtack_oe
);
  localparam int STROBES = 2;

  logic [STROBES-1:0] strobe_sync_n;
  logic [VEC_W-1:0]   vec_cur;
  logic               unused_bus;

  assign unused_bus = ^{addr, uds_n, rw_n};

  iack_sync #(.WIDTH(STROBES), .STAGES(SYNC_N), .RST_VAL(1'b1)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .async_in ({iack_n, lds_n}),
    .sync_out (strobe_sync_n)
  );

  iack_vec_reg #(.VEC_W(VEC_W), .RST_VEC(RST_VEC)) vreg_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (vec_wr_en),
    .wr_data (vec_wr_data),
    .vec     (vec_cur)
  );

  iack_seq_fsm #(.VEC_W(VEC_W)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .ack_act   (~strobe_sync_n[1]),
    .lds_act   (~strobe_sync_n[0]),
    .vec_in    (vec_cur),
    .data_out  (data_out),
    .data_oe   (data_oe),
    .dtack_out (dtack_out),
    .dtack_oe  (dtack_oe)
  );
endmodule

// File: rtl/iack_responder_chk.sv
module iack_responder_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [VEC_W-1:0] data_out,
  input logic             data_oe,
  input logic             dtack_out,
  input logic             dtack_oe
);
  AST_DATA_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (dtack_oe && !dtack_out)); // R2
  AST_VEC_STEADY: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe)) |-> $stable(data_out)); // R4
  AST_DATA_FLOATS_FIRST: assert property (@(posedge clk) disable iff (rst)
    $fell(data_oe) |-> (dtack_oe && !dtack_out)); // R5
  AST_NEGATE_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_oe) |-> $past(dtack_out)); // R5
  AST_NEGATE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (dtack_oe && dtack_out) |=> !dtack_oe); // R6
  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (rst)
    $fell(data_oe) |=> (dtack_oe && dtack_out)); // R6
endmodule

bind iack_vector_responder iack_responder_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst(rst), .data_out(data_out), .data_oe(data_oe),
  .dtack_out(dtack_out), .dtack_oe(dtack_oe)
);

// File: tb/iack_vector_responder_tb.sv
module iack_vector_responder_tb_top;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 23;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              iack_n = 1'b1, lds_n = 1'b1, uds_n = 1'b1, rw_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              vec_wr_en = 1'b0;
  logic [VEC_W-1:0]  vec_wr_data = '0;
  logic [VEC_W-1:0]  data_out;
  logic              data_oe, dtack_out, dtack_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  iack_vector_responder dut_i (
    .clk(clk), .rst(rst), .iack_n(iack_n), .lds_n(lds_n), .uds_n(uds_n),
    .rw_n(rw_n), .addr(addr), .vec_wr_en(vec_wr_en), .vec_wr_data(vec_wr_data),
    .data_out(data_out), .data_oe(data_oe), .dtack_out(dtack_out),
    .dtack_oe(dtack_oe)
  );

  // bit 8: 1 = host releases lds_n, 0 = host releases iack_n; bits 7:0 vector
  localparam logic [8:0] VEC_TABLE [5] = '{
    {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h81}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load_vec(input logic [7:0] v);
    vec_wr_data = v; vec_wr_en = 1'b1;
    tick(1);
    vec_wr_en = 1'b0;
  endtask

  // {data_oe, dtack_out, dtack_oe}
  function automatic logic [2:0] pads();
    return {data_oe, dtack_out, dtack_oe};
  endfunction

  task automatic both_high_wait();
    iack_n = 1'b1; lds_n = 1'b1;
    tick(4);
  endtask

  initial begin
    tick(3);
    chk("R1 reset enables", {30'd0, data_oe, dtack_oe}, 32'd0);
    rst = 1'b0;
    tick(1);
    chk("R1 enables after reset", {30'd0, data_oe, dtack_oe}, 32'd0);
    tick(2);

    // default vector
    iack_n = 1'b0; lds_n = 1'b0;
    tick(4);
    chk("R1 default vector", data_out, 32'h0F);
    chk("R2 drive pads", pads(), 3'b101);
    both_high_wait();

    // table walk
    for (int i = 0; i < 5; i++) begin
      load_vec(VEC_TABLE[i][7:0]);
      iack_n = 1'b0; lds_n = 1'b0;
      tick(2);
      chk("R2 no early response", pads(), 3'b010);
      tick(1);
      chk("R2 vector on bus", data_out, VEC_TABLE[i][7:0]);
      chk("R2 drive pads", pads(), 3'b101);
      tick(2);
      chk("R4 vector held", data_out, VEC_TABLE[i][7:0]);
      if (VEC_TABLE[i][8]) lds_n = 1'b1; else iack_n = 1'b1;
      tick(2);
      chk("R6 still driving", pads(), 3'b101);
      tick(1);
      chk("R5 data floats first", pads(), 3'b001);
      tick(1);
      chk("R5 acknowledge negated driven", pads(), 3'b011);
      tick(1);
      chk("R6 acknowledge floats", pads(), 3'b010);
      both_high_wait();
    end

    // single strobe only
    iack_n = 1'b0;
    tick(6);
    chk("R3 iack alone", pads(), 3'b010);
    iack_n = 1'b1; lds_n = 1'b0;
    tick(6);
    chk("R3 lds alone", pads(), 3'b010);
    both_high_wait();

    // ignored inputs and mid-cycle write
    load_vec(8'h6D);
    iack_n = 1'b0; lds_n = 1'b0;
    tick(4);
    addr = '1; uds_n = 1'b0; rw_n = 1'b0;
    tick(4);
    chk("R7 addr/uds/rw ignored", data_out, 32'h6D);
    chk("R7 pads unchanged", pads(), 3'b101);
    load_vec(8'h55);
    tick(3);
    chk("R4 write during drive", data_out, 32'h6D);

    // re-arm: release lds only then reassert
    lds_n = 1'b1;
    tick(6);
    lds_n = 1'b0;
    tick(6);
    chk("R8 no restart without both high", pads(), 3'b010);
    both_high_wait();
    iack_n = 1'b0; lds_n = 1'b0;
    tick(4);
    chk("R8 restart after both high", pads(), 3'b101);
    chk("R9 new vector used", data_out, 32'h55);
    both_high_wait();
    addr = '0; uds_n = 1'b1; rw_n = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule